// File: doc/BRIEF.md
# Pixel-Phase Edge Generator

This block produces the fast clocks that a CCD readout chain needs within one pixel period. A phase clock running 48 times faster than the pixel rate steps a phase counter through 48 positions per pixel. Programmable edge codes set where each output changes level. The outputs are a reset-gate pulse, two horizontal clocks with forced complements, and two one-cycle sample strobes, one for the reset level and one for the data level.

Edge codes use quadrant form. The upper two bits pick one of four quadrants of twelve steps, and the lower four bits pick the step within that quadrant. Software-side logic writes codes through a parallel port into shadow registers. The shadows move to the active set only when the counter wraps, so a pulse never changes shape in the middle of a pixel period.

Each pulse output is driven by its own two-state machine. In state PULSE_IDLE the output level is inactive. In state PULSE_ACTIVE it is active. The LEAD transition (IDLE to ACTIVE) happens when the phase matches a valid rising code, as long as the falling code does not decode to the same position. The TRAIL transition (ACTIVE to IDLE) happens when the phase matches a valid falling code. Every other case holds the current state.

Top module: `pixphase_edge_gen`

## Requirements
- R1: `phase_o` counts 0,1,…,47 on successive fast clocks and returns to 0 after 47.
- R2: An edge code decodes to position 12×code[5:4] + code[3:0]. Codes whose code[3:0] is 12 to 15 are invalid.
- R3: A pulse output becomes active in the cycle after `phase_o` equals its rising position and goes inactive in the cycle after `phase_o` equals its falling position. It is therefore active while `phase_o` runs from rise+1 through fall.
- R4: When the falling position is below the rising position, the pulse stays active across the period boundary until the falling position in the next period.
- R5: An invalid code causes no transition for that edge. Equal valid rising and falling positions produce no pulse from the inactive state.
- R6: Polarity bits invert the port level: bit 0 for `rg_o`, bit 1 for `h1_o`, bit 2 for `h3_o`.
- R7: `h2_o` is always the inverse of `h1_o`, and `h4_o` is always the inverse of `h3_o`.
- R8: `shr_o` and `shd_o` are each high for exactly one fast cycle per period, in the cycle where `phase_o` equals their decoded position + 1 (mod 48). With an invalid code the strobe stays low.
- R9: A write goes to a shadow register. It reaches the active set at the clock edge where `phase_o` moves from 47 to 0, and governs only later periods. The address map is: 0/1 reset-gate rise/fall, 2/3 first horizontal rise/fall, 4/5 second horizontal rise/fall, 6 reset-level strobe, 7 data-level strobe, 8 polarity. Addresses 9 to 15 are ignored.
- R10: `code_err_o` becomes set after a write of an invalid code to addresses 0 to 7. Writes to address 8 or to addresses 9 to 15 never set it. Once set, it stays set until reset.
- R11: During and after reset, `phase_o` is 0, all codes and polarity bits are 0, `rg_o`, `h1_o`, `h3_o`, `shr_o` and `code_err_o` are 0, and `h2_o` and `h4_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock, 48 cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 6 | Edge code, or polarity bits in [2:0] |
| phase_o | output | 6 | Current phase position |
| rg_o | output | 1 | Reset-gate pulse |
| h1_o | output | 1 | First horizontal clock |
| h2_o | output | 1 | Inverse of h1_o |
| h3_o | output | 1 | Second horizontal clock |
| h4_o | output | 1 | Inverse of h3_o |
| shr_o | output | 1 | Reset-level sample strobe |
| shd_o | output | 1 | Data-level sample strobe |
| code_err_o | output | 1 | Sticky invalid-code flag |

## Verification
The bench builds the block with its default geometry of four quadrants of twelve steps. At this size every one of the 64 codes, including all sixteen invalid ones, can be reached by random writes. A period is short enough that several thousand cycles cover many shadow transfers. This lets writes land at every phase, including the phase-47 boundary cycle, and lets wrap-around pulses and end-of-period strobe positions recur across many configurations.

// File: rtl/pixphase_pkg.sv
package pixphase_pkg;
    localparam int QUAD_STEPS = 12;
    localparam int QUADS      = 4;
    localparam int PHASES     = QUAD_STEPS * QUADS;
    localparam int PH_W       = $clog2(PHASES);
    localparam int OFF_W      = $clog2(QUAD_STEPS);
    localparam int QB_W       = $clog2(QUADS);
    localparam int CODE_W     = QB_W + OFF_W;
    localparam int NPULSE     = 3;
    localparam int NSTROBE    = 2;
    localparam int NEDGE      = 2 * NPULSE + NSTROBE;
    localparam int POL_ADDR   = NEDGE;
    localparam int ADDR_W     = $clog2(NEDGE + 1);
    localparam int EI_W       = $clog2(NEDGE);

    typedef enum logic {PULSE_IDLE = 1'b0, PULSE_ACTIVE = 1'b1} pulse_st_t;

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return c[OFF_W-1:0] < OFF_W'(QUAD_STEPS);
    endfunction

    function automatic logic [PH_W-1:0] code_pos(input logic [CODE_W-1:0] c);
        return PH_W'(c[CODE_W-1:OFF_W]) * PH_W'(QUAD_STEPS) + PH_W'(c[OFF_W-1:0]);
    endfunction
endpackage

// File: rtl/pp_phase_counter.sv
module pp_phase_counter
    import pixphase_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_q,
    output logic            wrap
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    always_comb wrap = (phase_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase_q <= '0;
        else if (wrap) phase_q <= '0;
        else           phase_q <= phase_q + PH_W'(1);
    end

    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == LAST) |=> (phase_q == '0));
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != LAST) |=> (phase_q == $past(phase_q) + PH_W'(1)));
    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
endmodule

// File: rtl/pp_regfile.sv
module pp_regfile
    import pixphase_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CODE_W-1:0]            wr_data,
    input  logic                         wrap,
    output logic [NEDGE-1:0][CODE_W-1:0] act_code,
    output logic [NPULSE-1:0]            act_pol,
    output logic                         err_q
);
    logic [NEDGE-1:0][CODE_W-1:0] shd_code;
    logic [NPULSE-1:0]            shd_pol;
    logic                         edge_wr, pol_wr, err_set;

    always_comb begin
        edge_wr = wr_en && (wr_addr < ADDR_W'(NEDGE));
        pol_wr  = wr_en && (wr_addr == ADDR_W'(POL_ADDR));
        err_set = edge_wr && !code_ok(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_code <= '0;
            shd_pol  <= '0;
            act_code <= '0;
            act_pol  <= '0;
            err_q    <= 1'b0;
        end else begin
            if (edge_wr) shd_code[wr_addr[EI_W-1:0]] <= wr_data;
            if (pol_wr)  shd_pol <= wr_data[NPULSE-1:0];
            if (wrap) begin
                act_code <= shd_code;
                act_pol  <= shd_pol;
            end
            if (err_set) err_q <= 1'b1;
        end
    end

    a_r9_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_code) && $stable(act_pol)));
    a_r9_take_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (act_code == $past(shd_code) && act_pol == $past(shd_pol)));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/pp_pulse_chan.sv
module pp_pulse_chan
    import pixphase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_i,
    input  logic [CODE_W-1:0] lead_code,
    input  logic [CODE_W-1:0] trail_code,
    output logic              level
);
    pulse_st_t         st_q, st_nxt;
    logic              lead_ok, trail_ok, lead_hit, trail_hit, same_pos;
    logic [PH_W-1:0]   lead_pos, trail_pos;

    always_comb begin
        lead_ok   = code_ok(lead_code);
        trail_ok  = code_ok(trail_code);
        lead_pos  = code_pos(lead_code);
        trail_pos = code_pos(trail_code);
        lead_hit  = lead_ok && (phase_i == lead_pos);
        trail_hit = trail_ok && (phase_i == trail_pos);
        same_pos  = lead_ok && trail_ok && (lead_pos == trail_pos);
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            PULSE_IDLE:   if (lead_hit && !same_pos) st_nxt = PULSE_ACTIVE;
            PULSE_ACTIVE: if (trail_hit)             st_nxt = PULSE_IDLE;
            default:                                 st_nxt = PULSE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PULSE_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb level = (st_q == PULSE_ACTIVE);

    a_r3_lead_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> ($past(lead_ok) && $past(phase_i) == $past(lead_pos)));
    a_r4_trail_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level) |-> ($past(trail_ok) && $past(phase_i) == $past(trail_pos)));
    a_r5_invalid_lead_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && !lead_ok) |=> !level);
endmodule

// File: rtl/pp_strobe_chan.sv
module pp_strobe_chan
    import pixphase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_i,
    input  logic [CODE_W-1:0] pos_code,
    output logic              stb_q
);
    logic            ok;
    logic [PH_W-1:0] pos;

    always_comb begin
        ok  = code_ok(pos_code);
        pos = code_pos(pos_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= ok && (phase_i == pos);
    end

    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);
    a_r8_at_position: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> ($past(ok) && $past(phase_i) == $past(pos)));
endmodule

// File: rtl/pixphase_edge_gen.sv
module pixphase_edge_gen
    import pixphase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [PH_W-1:0]   phase_o,
    output logic              rg_o,
    output logic              h1_o,
    output logic              h2_o,
    output logic              h3_o,
    output logic              h4_o,
    output logic              shr_o,
    output logic              shd_o,
    output logic              code_err_o
);
    logic                         wrap;
    logic [NEDGE-1:0][CODE_W-1:0] act_code;
    logic [NPULSE-1:0]            act_pol;
    logic [NPULSE-1:0]            lvl;
    logic [NSTROBE-1:0]           stb;

    pp_phase_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_o), .wrap(wrap)
    );

    pp_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wrap(wrap), .act_code(act_code),
        .act_pol(act_pol), .err_q(code_err_o)
    );

    for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
        pp_pulse_chan u_pulse (
            .clk(clk), .rst_n(rst_n), .phase_i(phase_o),
            .lead_code(act_code[2*g]), .trail_code(act_code[2*g+1]),
            .level(lvl[g])
        );
    end

    for (genvar s = 0; s < NSTROBE; s++) begin : g_strobe
        pp_strobe_chan u_stb (
            .clk(clk), .rst_n(rst_n), .phase_i(phase_o),
            .pos_code(act_code[2*NPULSE+s]), .stb_q(stb[s])
        );
    end

    always_comb begin
        rg_o  = lvl[0] ^ act_pol[0];
        h1_o  = lvl[1] ^ act_pol[1];
        h3_o  = lvl[2] ^ act_pol[2];
        h2_o  = ~h1_o;
        h4_o  = ~h3_o;
        shr_o = stb[0];
        shd_o = stb[1];
    end
endmodule

// File: tb/pixphase_edge_gen_tb.sv
module pixphase_edge_gen_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [5:0] phase_o;
    logic rg_o, h1_o, h2_o, h3_o, h4_o, shr_o, shd_o, code_err_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    int       m_cnt;
    bit [5:0] m_sh [8], m_act [8];
    bit [2:0] m_shp, m_actp;
    bit       m_st [3];
    bit       m_stb [2];
    bit       m_err;

    pixphase_edge_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .phase_o(phase_o), .rg_o(rg_o), .h1_o(h1_o),
        .h2_o(h2_o), .h3_o(h3_o), .h4_o(h4_o), .shr_o(shr_o),
        .shd_o(shd_o), .code_err_o(code_err_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit okc(bit [5:0] c);
        return c[3:0] < 12;
    endfunction

    function automatic int posc(bit [5:0] c);
        return int'(c[5:4]) * 12 + int'(c[3:0]);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            if (n_bad < 30) $display("FAIL %s: actual %0d expected %0d (phase %0d)", req, act, exp, m_cnt);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_shp = 0; m_actp = 0; m_err = 0;
        for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_act[i] = 0; end
        for (int i = 0; i < 3; i++) m_st[i] = 0;
        for (int i = 0; i < 2; i++) m_stb[i] = 0;
    endtask

    task automatic model_step(bit we, bit [3:0] a, bit [5:0] d);
        bit nst [3];
        bit nstb [2];
        for (int g = 0; g < 3; g++) begin
            bit [5:0] lr, tr;
            bit lh, th, same;
            lr = m_act[2*g]; tr = m_act[2*g+1];
            lh = okc(lr) && posc(lr) == m_cnt;
            th = okc(tr) && posc(tr) == m_cnt;
            same = okc(lr) && okc(tr) && posc(lr) == posc(tr);
            nst[g] = m_st[g] ? !th : (lh && !same);
        end
        for (int s = 0; s < 2; s++)
            nstb[s] = okc(m_act[6+s]) && posc(m_act[6+s]) == m_cnt;
        if (m_cnt == 47) begin
            for (int i = 0; i < 8; i++) m_act[i] = m_sh[i];
            m_actp = m_shp;
        end
        if (we && a < 8) begin
            m_sh[a[2:0]] = d;
            if (!okc(d)) m_err = 1;
        end
        if (we && a == 8) m_shp = d[2:0];
        m_cnt = (m_cnt == 47) ? 0 : m_cnt + 1;
        for (int g = 0; g < 3; g++) m_st[g] = nst[g];
        for (int s = 0; s < 2; s++) m_stb[s] = nstb[s];
    endtask

    task automatic compare_all();
        bit e1, e3;
        e1 = m_st[1] ^ m_actp[1];
        e3 = m_st[2] ^ m_actp[2];
        chk("R1 phase", int'(phase_o), m_cnt);
        chk("R3 rg", int'(rg_o), int'(m_st[0] ^ m_actp[0]));
        chk("R4 h1", int'(h1_o), int'(e1));
        chk("R7 h2", int'(h2_o), int'(!e1));
        chk("R5 h3", int'(h3_o), int'(e3));
        chk("R7 h4", int'(h4_o), int'(!e3));
        chk("R8 shr", int'(shr_o), int'(m_stb[0]));
        chk("R8 shd", int'(shd_o), int'(m_stb[1]));
        chk("R10 err", int'(code_err_o), int'(m_err));
    endtask

    task automatic tick(bit we, bit [3:0] a, bit [5:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(we, a, d);
        #1;
        compare_all();
        wr_en = 0;
    endtask

    task automatic wait_phase(int p);
        do tick(0, 0, 0); while (m_cnt != p);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 phase", int'(phase_o), 0);
        chk("R11 rg", int'(rg_o), 0);
        chk("R11 h2", int'(h2_o), 1);
        chk("R11 h4", int'(h4_o), 1);
        chk("R11 shr", int'(shr_o), 0);
        chk("R11 err", int'(code_err_o), 0);
        rst_n = 1;

        // R9: rg rise pos 2, fall 0x13 = pos 15 (R2 quadrant decode)
        tick(1, 0, 6'h02);
        tick(1, 1, 6'h13);
        wait_phase(5);
        chk("R9 not yet applied", int'(rg_o), 0);
        wait_phase(0);
        wait_phase(3);
        chk("R3 rise", int'(rg_o), 1);
        wait_phase(15);
        chk("R2 high at fall pos", int'(rg_o), 1);
        wait_phase(16);
        chk("R3 fall", int'(rg_o), 0);

        // R4: h1 rise 0x31 = 37, fall 5
        tick(1, 2, 6'h31);
        tick(1, 3, 6'h05);
        wait_phase(0);
        wait_phase(40);
        chk("R4 high", int'(h1_o), 1);
        chk("R7 h2 inverse", int'(h2_o), 0);
        wait_phase(3);
        chk("R4 wrap high", int'(h1_o), 1);
        wait_phase(6);
        chk("R4 wrap fall", int'(h1_o), 0);

        // R6 polarity on h1; R10 polarity and unmapped writes set no error
        tick(1, 8, 6'h3A);
        tick(1, 12, 6'h3F);
        chk("R10 no err", int'(code_err_o), 0);
        wait_phase(0);
        wait_phase(10);
        chk("R6 inverted", int'(h1_o), 1);
        chk("R6 h2", int'(h2_o), 0);

        // R8 strobes: shr 0x24 = 28, shd 0x3B = 47
        tick(1, 6, 6'h24);
        tick(1, 7, 6'h3B);
        wait_phase(0);
        wait_phase(29);
        chk("R8 shr pulse", int'(shr_o), 1);
        wait_phase(30);
        chk("R8 shr single", int'(shr_o), 0);
        wait_phase(0);
        chk("R8 shd at wrap", int'(shd_o), 1);

        // R5 invalid lead and equal edges; R10 error set
        tick(1, 4, 6'h0D);
        chk("R10 err set", int'(code_err_o), 1);
        tick(1, 5, 6'h04);
        tick(1, 0, 6'h10);
        tick(1, 1, 6'h10);
        wait_phase(0);
        wait_phase(20);
        chk("R5 invalid lead", int'(h3_o), 0);
        chk("R5 equal edges", int'(rg_o), 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit we;
            we = ($urandom % 6) == 0;
            tick(we, 4'($urandom % 16), 6'($urandom));
        end

        // R11 reset mid-run clears state
        #2;
        rst_n = 0;
        #1;
        model_reset();
        chk("R11 err cleared", int'(code_err_o), 0);
        chk("R11 phase cleared", int'(phase_o), 0);
        chk("R11 h4", int'(h4_o), 1);
        @(posedge clk); #2;
        rst_n = 1;
        for (int i = 0; i < 100; i++) tick(0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule